// File: doc/BRIEF.md
# Floating-Point Exception Status Updater

This block holds the floating-point status word of a processor core together with the program counter and next program counter of the instruction being retired. When an arithmetic unit reports that an operation has finished, the block takes a 5-bit exception vector. The bits are, from bit 4 down to bit 0: invalid, overflow, underflow, divide-by-zero and inexact. The block checks this vector against the trap-enable mask held in the status word.

With no enabled exception, the operation retires quietly. The vector becomes the current-exception field, it is ORed into the sticky accrued field, and the PC pair steps forward. When an enabled exception is present, the block requests a trap. It keeps exactly one enabled exception, chosen by fixed priority, as the current-exception field. It leaves the accrued field alone, marks the trap type as an IEEE exception, and freezes the PC pair so the handler sees the faulting instruction.

A context-load port lets the surrounding core write the whole status word and the PC pair, for example on a context switch or when software rewrites the mask.

Top module: `fpexc_status_unit`

## Requirements
- R1: After reset the status word is zero, PC is 0, nPC is 4 and the trap request is low.
- R2: A completion traps exactly when some bit of the exception vector is also set in the enable mask, which sits at status bits 27:23 with the same bit order as the vector.
- R3: On a trap, the current-exception field (status bits 4:0) holds a single bit. It is the enabled exception of highest priority, in the order invalid (bit 4), overflow (bit 3), underflow (bit 2), divide-by-zero (bit 1), inexact (bit 0).
- R4: With no trap, the current-exception field is replaced by the full vector, so a completion with an all-zero vector clears it.
- R5: With no trap, the accrued field (status bits 9:5) becomes its old value ORed with the vector. On a trap it is unchanged.
- R6: On a trap, status bit 14 is set. Every status bit outside the current field, the accrued field and bit 14 keeps its value on any completion.
- R7: With no trap, PC takes the old nPC and nPC becomes the old nPC plus 4.
- R8: On a trap, PC and nPC both keep their values.
- R9: The status word and the PC pair change at the clock edge that samples the completion strobe. The trap request is high for exactly the one cycle after that edge, and only when the completion trapped.
- R10: A context load writes the status word, PC and nPC at the sampling edge. If a completion is strobed in the same cycle, the completion is ignored and no trap is requested.
- R11: In a cycle with neither a completion nor a context load, the status word, PC and nPC hold, and the trap request stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctxLoad | input | 1 | Load status word and PC pair from the ctx inputs |
| ctxStatus | input | 64 | Status word to load |
| ctxPc | input | 64 | PC to load |
| ctxNpc | input | 64 | nPC to load |
| opDone | input | 1 | Completion strobe of a floating-point operation |
| opFlags | input | 5 | Exception vector of the completing operation |
| trapReq | output | 1 | One-cycle trap request |
| statusOut | output | 64 | Current status word |
| pcOut | output | 64 | Current PC |
| npcOut | output | 64 | Current nPC |

## Verification
Every one of the 1024 pairs of enable mask and exception vector is loaded and completed once, each against a distinct status background and PC pair. Pairs with no overlap between mask and vector separate the quiet path from the trap path, and all-zero vectors confirm that the current field is cleared. Vectors with several enabled bits expose any error in the priority order. Vectors with bits that are set but not enabled show whether the reduction masks before it picks, and whether accrual uses the unmasked vector. A final case strobes a completion together with a context load to confirm which one takes precedence.

// File: rtl/fpexc_pkg.sv
package fpexc_pkg;
  parameter int NFLAGS = 5;

  typedef struct packed {
    logic              load;    // take the context inputs
    logic              commit;  // retire a completed operation
    logic              trap;    // the retiring operation traps
    logic [NFLAGS-1:0] cexc;    // new current-exception field
  } strobes_t;
endpackage

// File: rtl/fpexc_ctrl.sv
module fpexc_ctrl
  import fpexc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctxLoad,
  input  logic              opDone,
  input  logic [NFLAGS-1:0] opFlags,
  input  logic [NFLAGS-1:0] trapMask,
  output strobes_t          strobes
);
  logic [NFLAGS-1:0] enabledFlags;
  logic [NFLAGS-1:0] pickedFlag;
  logic              anyEnabled;
  logic              found;

  assign enabledFlags = opFlags & trapMask;
  assign anyEnabled   = |enabledFlags;

  // Fixed priority: the most significant enabled bit wins.
  always_comb begin
    pickedFlag = '0;
    found      = 1'b0;
    for (int i = NFLAGS - 1; i >= 0; i--) begin
      if (enabledFlags[i] && !found) begin
        pickedFlag[i] = 1'b1;
        found         = 1'b1;
      end
    end
  end

  always_comb begin
    strobes.load   = ctxLoad;
    strobes.commit = opDone && !ctxLoad;
    strobes.trap   = opDone && !ctxLoad && anyEnabled;
    strobes.cexc   = anyEnabled ? pickedFlag : opFlags;
  end

  p_one_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.trap |-> ($countones(strobes.cexc) == 1));

  p_pick_enabled_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.trap |-> ((strobes.cexc & trapMask & opFlags) == strobes.cexc));

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && !strobes.trap) |-> ((opFlags & trapMask) == '0));

  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctxLoad |-> (!strobes.commit && !strobes.trap));
endmodule

// File: rtl/fpexc_datapath.sv
module fpexc_datapath
  import fpexc_pkg::*;
#(
  parameter int          STAT_W   = 64,
  parameter int          PC_W     = 64,
  parameter int          MASK_LSB = 23,
  parameter int          ACC_LSB  = 5,
  parameter int          CUR_LSB  = 0,
  parameter int          TT_BIT   = 14,
  parameter int          PC_STEP  = 4,
  parameter logic [63:0] PC_RST   = 64'd0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [STAT_W-1:0] ctxStatus,
  input  logic [PC_W-1:0]   ctxPc,
  input  logic [PC_W-1:0]   ctxNpc,
  output logic [NFLAGS-1:0] trapMask,
  output logic [STAT_W-1:0] status,
  output logic [PC_W-1:0]   pc,
  output logic [PC_W-1:0]   npc,
  output logic              trapPulse
);
  localparam logic [PC_W-1:0] PC_INIT  = PC_W'(PC_RST);
  localparam logic [PC_W-1:0] STEP_VAL = PC_W'(PC_STEP);

  logic [NFLAGS-1:0] accNow;

  assign trapMask = status[MASK_LSB +: NFLAGS];
  assign accNow   = status[ACC_LSB +: NFLAGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status    <= '0;
      pc        <= PC_INIT;
      npc       <= PC_INIT + STEP_VAL;
      trapPulse <= 1'b0;
    end else begin
      trapPulse <= strobes.trap;
      if (strobes.load) begin
        status <= ctxStatus;
        pc     <= ctxPc;
        npc    <= ctxNpc;
      end else if (strobes.commit) begin
        status[CUR_LSB +: NFLAGS] <= strobes.cexc;
        if (strobes.trap) begin
          status[TT_BIT] <= 1'b1;
        end else begin
          status[ACC_LSB +: NFLAGS] <= accNow | strobes.cexc;
          pc  <= npc;
          npc <= npc + STEP_VAL;
        end
      end
    end
  end

  p_advance_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && !strobes.trap) |=>
      (pc == $past(npc)) && (npc == $past(npc) + STEP_VAL));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.trap |=> ($stable(pc) && $stable(npc)));

  p_trap_type_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.trap |=> status[TT_BIT]);

  p_no_accrue_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.trap |=> $stable(status[ACC_LSB +: NFLAGS]));

  p_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.commit) |=> ($stable(status) && $stable(pc) && !trapPulse));

  p_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (pc == $past(ctxPc)) && (npc == $past(ctxNpc)) && (status == $past(ctxStatus)));
endmodule

// File: rtl/fpexc_status_unit.sv
module fpexc_status_unit
  import fpexc_pkg::*;
#(
  parameter int STAT_W = 64,
  parameter int PC_W   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctxLoad,
  input  logic [STAT_W-1:0] ctxStatus,
  input  logic [PC_W-1:0]   ctxPc,
  input  logic [PC_W-1:0]   ctxNpc,
  input  logic              opDone,
  input  logic [NFLAGS-1:0] opFlags,
  output logic              trapReq,
  output logic [STAT_W-1:0] statusOut,
  output logic [PC_W-1:0]   pcOut,
  output logic [PC_W-1:0]   npcOut
);
  strobes_t          strobes;
  logic [NFLAGS-1:0] trapMask;

  fpexc_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctxLoad  (ctxLoad),
    .opDone   (opDone),
    .opFlags  (opFlags),
    .trapMask (trapMask),
    .strobes  (strobes)
  );

  fpexc_datapath #(
    .STAT_W (STAT_W),
    .PC_W   (PC_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .ctxStatus (ctxStatus),
    .ctxPc     (ctxPc),
    .ctxNpc    (ctxNpc),
    .trapMask  (trapMask),
    .status    (statusOut),
    .pc        (pcOut),
    .npc       (npcOut),
    .trapPulse (trapReq)
  );
endmodule

// File: tb/test_fpexc_status_unit.sv
module test_fpexc_status_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctxLoad = 1'b0;
  logic [63:0] ctxStatus = '0;
  logic [63:0] ctxPc = '0;
  logic [63:0] ctxNpc = '0;
  logic        opDone = 1'b0;
  logic [4:0]  opFlags = '0;
  logic        trapReq;
  logic [63:0] statusOut, pcOut, npcOut;

  int testCount = 0;
  int failCount = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  fpexc_status_unit i_fpexc_status_unit (
    .clk(clk), .rstN(rstN), .ctxLoad(ctxLoad), .ctxStatus(ctxStatus),
    .ctxPc(ctxPc), .ctxNpc(ctxNpc), .opDone(opDone), .opFlags(opFlags),
    .trapReq(trapReq), .statusOut(statusOut), .pcOut(pcOut), .npcOut(npcOut)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] prioPick(input logic [4:0] v);
    if (v[4])      return 5'b10000;  // invalid
    else if (v[3]) return 5'b01000;  // overflow
    else if (v[2]) return 5'b00100;  // underflow
    else if (v[1]) return 5'b00010;  // divide-by-zero
    else if (v[0]) return 5'b00001;  // inexact
    return 5'b00000;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 status", statusOut, 64'd0);
    check("R1 pc", pcOut, 64'd0);
    check("R1 npc", npcOut, 64'd4);
    check("R1 trap", {63'd0, trapReq}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 32; m++) begin
      for (int f = 0; f < 32; f++) begin
        logic [4:0]  acc0, cur0, masked, cexcE, accE;
        logic [63:0] base, statE, pc0, npc0, pcE, npcE;
        logic        trapE;
        acc0 = 5'((m * 7 + f * 3) & 31);
        cur0 = 5'((m + f * 5) & 31);
        base = 64'hC3A5_0F00_0000_0000 | 64'h0000_0000_0002_8C00
             | (64'(m) << 23) | (64'(acc0) << 5) | 64'(cur0);
        pc0  = 64'h1000 + 64'(m * 32 + f) * 64'h100;
        npc0 = pc0 + 64'h40;
        // load context
        ctxLoad = 1'b1; ctxStatus = base; ctxPc = pc0; ctxNpc = npc0;
        @(negedge clk);
        ctxLoad = 1'b0; opDone = 1'b1; opFlags = 5'(f);
        @(negedge clk);
        opDone = 1'b0;
        masked = 5'(f) & 5'(m);
        trapE  = |masked;
        cexcE  = trapE ? prioPick(masked) : 5'(f);
        accE   = trapE ? acc0 : (acc0 | 5'(f));
        statE  = base;
        statE[4:0] = cexcE;
        statE[9:5] = accE;
        if (trapE) statE[14] = 1'b1;
        pcE  = trapE ? pc0 : npc0;
        npcE = trapE ? npc0 : npc0 + 64'd4;
        check("R2 trap decision", {63'd0, trapReq}, {63'd0, trapE});
        if (trapE) check("R3 reduced flag", {59'd0, statusOut[4:0]}, {59'd0, cexcE});
        else       check("R4 current field", {59'd0, statusOut[4:0]}, {59'd0, cexcE});
        check("R5 accrued field", {59'd0, statusOut[9:5]}, {59'd0, accE});
        check("R6 status word", statusOut, statE);
        if (trapE) begin
          check("R8 pc hold", pcOut, pcE);
          check("R8 npc hold", npcOut, npcE);
        end else begin
          check("R7 pc step", pcOut, pcE);
          check("R7 npc step", npcOut, npcE);
        end
        @(negedge clk);
        check("R9 pulse width", {63'd0, trapReq}, 64'd0);
        check("R11 idle status", statusOut, statE);
        check("R11 idle pc", pcOut, pcE);
      end
    end

    // R10: load and completion in the same cycle
    ctxLoad = 1'b1; ctxStatus = 64'h0000_0000_0F80_0000; ctxPc = 64'h2000; ctxNpc = 64'h2004;
    opDone = 1'b1; opFlags = 5'b11111;
    @(negedge clk);
    ctxLoad = 1'b0; opDone = 1'b0;
    check("R10 status", statusOut, 64'h0000_0000_0F80_0000);
    check("R10 pc", pcOut, 64'h2000);
    check("R10 npc", npcOut, 64'h2004);
    check("R10 no trap", {63'd0, trapReq}, 64'd0);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule